// File: doc/BRIEF.md
# Memory-Mapped General-Purpose I/O Bank

This block gives software eight general-purpose pins behind a small register bus. Software picks, pin by pin, whether the pin is driven or only observed. It also sets the level that driven pins carry, and it reads back the level present on every pin. The block does not contain pad cells. It brings out three separate vectors: the output level, the output enable and the raw pin input. A chip top level wraps each pin in its own tri-state pad buffer, and a pad whose enable bit is 0 floats.

The bus carries one access per cycle. The access is qualified by a select, a write flag, a byte offset and 32-bit write data, and read data returns in the same cycle. There are three registers:

- **Direction register, offset 0x00.** Read/write. A 1 bit makes that pin an output.
- **Drive-level register, offset 0x04.** Read/write. Holds the level each driven pin carries.
- **Pin-level register, offset 0x08.** Read-only. Returns the level on each pin.

Every pin input passes through a two-flop synchronizer before software can read it, and no filtering or debouncing is applied. Several copies of the block can sit at different bases, because only the low offset bits reach it.

Top module: `gpio_bank`

## Requirements
- R1: After reset, pin_oe and pin_o are all 0, so every pin floats, and the direction register (0x00) and drive-level register (0x04) read as 0.
- R2: A write to offset 0x00 stores write-data bits 7:0 as the direction. pin_oe shows the new value from the clock edge that takes the write, and a read of 0x00 returns it. Bit n set to 1 means pin n is driven.
- R3: A write to offset 0x04 stores write-data bits 7:0 as the drive level. pin_o shows the new value from the clock edge that takes the write, and a read of 0x04 returns it.
- R4: pin_o follows the drive-level register whatever the direction bits are. Clearing a direction bit only removes the enable for that pin and leaves the stored level unchanged.
- R5: A read of offset 0x08 returns the pin levels (bit n = pin n, 1 = high) sampled through two flops. A change on pin_i is not visible after one clock edge and is visible after the second edge.
- R6: No filtering is applied to inputs. A pin pulse that lasts one clock cycle appears in the 0x08 read for exactly one cycle, two edges later.
- R7: A write to offset 0x08 has no effect. The direction, the drive level and the pin-level reads are unchanged.
- R8: Accesses to any offset other than 0x00, 0x04 and 0x08 are ignored. This includes offsets that are not word aligned, such as 0x01, and offsets such as 0x0C. Writes to them change nothing, and reads of them return 0.
- R9: Read data bits 31:8 are always 0, and write-data bits 31:8 are discarded.
- R10: bus_rdata is 0 in any cycle without a read, meaning when bus_sel is low or when bus_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset within the bank |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of the read |
| pin_i | input | PINS (8) | Raw level from each pad |
| pin_o | output | PINS (8) | Level to drive on each pad |
| pin_oe | output | PINS (8) | Pad drive enable, 1 = drive |

## Verification
The bench builds the bank with its defaults: eight pins, an 8-bit offset and a 32-bit data path. With these values the three live offsets and their aligned and unaligned neighbours can be reached, and so can write data whose upper 24 bits are set. The two-flop synchronizer depth is also the default, so the bench can test the exact edge on which an input change appears, and it can test a one-cycle pulse passing through without being filtered.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe
);

  localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_OUT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_IN  = ADDR_W'(8'h08);
  localparam int PAD_W = DATA_W - PINS;

  logic [PINS-1:0] dir_q, out_q;
  logic [PINS-1:0] sync_q [SYNC_STAGES];
  logic [PINS-1:0] pin_lvl;

  wire wr_dir = bus_sel && bus_wr && (bus_addr == OFS_DIR);
  wire wr_out = bus_sel && bus_wr && (bus_addr == OFS_OUT);
  wire rd_any = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata[PINS-1:0];
      if (wr_out) out_q <= bus_wdata[PINS-1:0];
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pin_i;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_lvl = sync_q[SYNC_STAGES-1];
  assign pin_oe  = dir_q;
  assign pin_o   = out_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (bus_addr)
        OFS_DIR: bus_rdata = {{PAD_W{1'b0}}, dir_q};
        OFS_OUT: bus_rdata = {{PAD_W{1'b0}}, out_q};
        OFS_IN:  bus_rdata = {{PAD_W{1'b0}}, pin_lvl};
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (!rst_n) settle_q <= '0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_DIR) |=> pin_oe == $past(bus_wdata[PINS-1:0])); // R2
  AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_OUT) |=> pin_o == $past(bus_wdata[PINS-1:0])); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == OFS_DIR) |=> $stable(pin_oe)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == OFS_OUT) |=> $stable(pin_o)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PINS] == '0); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> bus_rdata == '0); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFS_DIR && bus_addr != OFS_OUT && bus_addr != OFS_IN) |-> bus_rdata == '0); // R8

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q >= 2'd2 && bus_sel && !bus_wr && bus_addr == OFS_IN)
          |-> bus_rdata[PINS-1:0] == $past(pin_i, 2)); // R5
    end
  endgenerate

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_i = '0, pin_o, pin_oe;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe));

  // entry: {req[3:0], wr, addr[7:0], wdata[31:0], exp_rdata[31:0], exp_pins{oe,o}[15:0]}
  localparam int NV = 14;
  localparam logic [92:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h00, 32'hFFFF_FF3C, 32'h0,  16'h3C00}, // R2 R9 upper bits dropped
    {4'd2,  1'b0, 8'h00, 32'h0,         32'h3C, 16'h3C00}, // R2
    {4'd3,  1'b1, 8'h04, 32'h1234_5681, 32'h0,  16'h3C81}, // R3
    {4'd3,  1'b0, 8'h04, 32'h0,         32'h81, 16'h3C81}, // R3
    {4'd5,  1'b0, 8'h08, 32'h0,         32'hA5, 16'h3C81}, // R5
    {4'd7,  1'b1, 8'h08, 32'hFF,        32'h0,  16'h3C81}, // R7
    {4'd7,  1'b0, 8'h00, 32'h0,         32'h3C, 16'h3C81}, // R7
    {4'd8,  1'b1, 8'h0C, 32'hFF,        32'h0,  16'h3C81}, // R8
    {4'd8,  1'b0, 8'h0C, 32'h0,         32'h0,  16'h3C81}, // R8
    {4'd8,  1'b1, 8'h01, 32'hFF,        32'h0,  16'h3C81}, // R8 unaligned
    {4'd8,  1'b0, 8'h01, 32'h0,         32'h0,  16'h3C81}, // R8
    {4'd4,  1'b1, 8'h00, 32'h0,         32'h0,  16'h0081}, // R4
    {4'd4,  1'b0, 8'h04, 32'h0,         32'h81, 16'h0081}, // R4
    {4'd3,  1'b1, 8'h04, 32'h0,         32'h0,  16'h0000}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 oe", {24'h0, pin_oe}, 32'h0);
    chk("R1 o",  {24'h0, pin_o}, 32'h0);
    do_read(8'h00); chk("R1 dir", bus_rdata, 32'h0);
    do_read(8'h04); chk("R1 out", bus_rdata, 32'h0);
    idle(); #1; chk("R10 idle", bus_rdata, 32'h0);

    pin_i = 8'hA5;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [92:0] e;
      e = VEC[i];
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = e[88]; bus_addr = e[87:80]; bus_wdata = e[79:48];
      #1;
      chk($sformatf("R%0d vec%0d rdata", e[92:89], i), bus_rdata, e[47:16]);
      @(posedge clk); #1;
      chk($sformatf("R%0d vec%0d pins", e[92:89], i), {16'h0, pin_oe, pin_o}, {16'h0, e[15:0]});
    end
    idle();

    // R5 two-edge synchronizer latency
    do_read(8'h08);
    pin_i = 8'h3C;
    @(posedge clk); #1; chk("R5 after one edge", bus_rdata, 32'hA5);
    @(posedge clk); #1; chk("R5 after two edges", bus_rdata, 32'h3C);

    // R6 one-cycle pulse passes unfiltered
    @(negedge clk); pin_i = 8'h00;
    repeat (3) @(negedge clk);
    pin_i = 8'h01;
    @(negedge clk); pin_i = 8'h00;
    #1; chk("R6 before", bus_rdata, 32'h0);
    @(posedge clk); #1; chk("R6 pulse seen", bus_rdata, 32'h1);
    @(posedge clk); #1; chk("R6 pulse gone", bus_rdata, 32'h0);

    // R7 write to input offset leaves input reads intact
    @(negedge clk); pin_i = 8'h5A; bus_wr = 1'b1; bus_wdata = 32'hFF;
    repeat (3) @(negedge clk);
    bus_wr = 1'b0; #1;
    chk("R7 input read", bus_rdata, 32'h5A);
    chk("R9 upper", {bus_rdata[31:8], 8'h0}, 32'h0);

    // R10 write cycle returns zero
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h0C; #1;
    chk("R10 write cycle", bus_rdata, 32'h0);
    idle();

    // R1 reset again clears state
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'hFF;
    @(negedge clk); bus_sel = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 reset oe", {24'h0, pin_oe}, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule